// File: doc/BRIEF.md
# Registered Two-Way Bus Transceiver

This block couples two byte-wide ports, A and B, in either or both directions. Each direction owns a capture register. The A register samples the A port on a rising edge of its own strobe, and the B register samples the B port on a rising edge of a second strobe. A per-direction source select picks what a port is driven with: the live value from the opposite port, or the byte held in the capture register. A pair of drive enables decides which ports are driven. The B side enable is active high and the A side enable is active low, so neither port, either port or both ports can be driven.

Each port is modelled in a synchronous design as an external driver (value plus valid) and a resolved bus value with a drive-enable flag. A bus keeper holds the last resolved level when nobody drives the port. When both directions are enabled on live data, the two ports form a loop that reinforces a single shared level. The top instantiates several independent slices (two by default, giving 16 bits). Each slice has its own strobes, selects and enables. Strobes are sampled on the system clock, and a rising edge is detected when the strobe is high now and was low on the previous clock.

Top module: `regxcvr_dual`

## Requirements
- R1: After the synchronous active-low reset, both capture registers and both bus keepers of every slice are zero. With no port driven, both buses therefore read 0x00.
- R2: In the clock where `cap_a` is high and was low on the previous clock, the A register loads the resolved A bus value, whatever the selects and enables are. The new value is visible from the next clock. A strobe held high loads only once.
- R3: The B register follows the same rule with `cap_b` and the resolved B bus value.
- R4: A select at 0 chooses live data from the opposite port. A select at 1 chooses the register filled from the opposite port: `sel_to_b`=1 drives B with the A register, and `sel_to_a`=1 drives A with the B register.
- R5: Port B is driven exactly when `oe_to_b`=1, and port A is driven exactly when `oe_to_a_n`=0. The drive-enable outputs report this.
- R6: With `oe_to_b`=0 and `oe_to_a_n`=1 (isolation), neither port is driven, and strobes still load the registers.
- R7: Bus priority is: the internal drive when enabled, else the external value when its valid is 1, else the keeper. The clash flag of a port is 1 exactly when its internal drive and its external valid are both active.
- R8: With the default keeper option, a port that is neither driven nor externally valid keeps its last resolved value on every following clock.
- R9: With both ports driven and both selects at 0, both buses carry one shared value: external A if valid, else external B if valid, else the A keeper value. The loop therefore retains data with no external driver.
- R10: With `sel_to_b`=0, B driven and A supplied externally, rising edges on both strobes in the same clock load the external A value into both registers.
- R11: With `sel_to_b`=1 and B driven, rising edges on both strobes in the same clock load the new A value into the A register and the previous A register value into the B register. Loading one value into both registers therefore needs staggered strobes.
- R12: Changing a select while the register value equals the live value leaves the driven bus unchanged, including within a clock.
- R13: Each slice responds only to its own controls and its own bits of the data buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_to_b | input | NUM_HALVES | Per slice, 1 drives port B |
| oe_to_a_n | input | NUM_HALVES | Per slice, 0 drives port A |
| cap_a | input | NUM_HALVES | Per slice, rising edge loads the A register |
| cap_b | input | NUM_HALVES | Per slice, rising edge loads the B register |
| sel_to_b | input | NUM_HALVES | Per slice, B source: 0 live A, 1 A register |
| sel_to_a | input | NUM_HALVES | Per slice, A source: 0 live B, 1 B register |
| a_in | input | SLICE_W*NUM_HALVES | External value on port A |
| a_in_vld | input | NUM_HALVES | Per slice, external A driver active |
| b_in | input | SLICE_W*NUM_HALVES | External value on port B |
| b_in_vld | input | NUM_HALVES | Per slice, external B driver active |
| a_bus | output | SLICE_W*NUM_HALVES | Resolved port A level |
| b_bus | output | SLICE_W*NUM_HALVES | Resolved port B level |
| a_drive_en | output | NUM_HALVES | Per slice, A driven by the block |
| b_drive_en | output | NUM_HALVES | Per slice, B driven by the block |
| a_clash | output | NUM_HALVES | Per slice, internal and external A drive together |
| b_clash | output | NUM_HALVES | Per slice, internal and external B drive together |

## Verification
Register loading and output routing can fall in the same clock. The sharpest case is two simultaneous strobe edges while the stored select feeds one register into the other port, where the B register must take the A register value from before the edge. The bench provokes this and the live-select loop-back case with both strobes rising together. It then reads both registers back through the stored selects with the external drivers removed, and compares the values with bytes it wrote earlier. The same overlap occurs at random during a sweep of all control combinations per slice, where a bench model decides each expected bus value and register load.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } src_sel_e;
endpackage

// File: rtl/xcvr_capture.sv
// Strobe-edge capture register: loads din when the strobe rises.
module xcvr_capture #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   logic strobe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         q        <= '0;
      end else begin
         strobe_q <= strobe;
         if (strobe && !strobe_q) q <= din;
      end
   end
endmodule

// File: rtl/xcvr_route.sv
// Combinational source selection and bus resolution for one slice.
module xcvr_route
   import xcvr_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         oe_b,
   input  logic         oe_a_n,
   input  logic         sel_b,
   input  logic         sel_a,
   input  logic         a_vld,
   input  logic         b_vld,
   input  logic [W-1:0] a_ext,
   input  logic [W-1:0] b_ext,
   input  logic [W-1:0] reg_a,
   input  logic [W-1:0] reg_b,
   input  logic [W-1:0] hold_a,
   input  logic [W-1:0] hold_b,
   output logic [W-1:0] a_bus,
   output logic [W-1:0] b_bus,
   output logic         a_en,
   output logic         b_en,
   output logic         a_clash,
   output logic         b_clash
);
   logic [W-1:0] src_a, src_b, shared, int_a, int_b;
   logic         ring;

   always_comb begin
      a_en   = ~oe_a_n;
      b_en   = oe_b;
      // level seen on each port without this block's own drive
      src_a  = a_vld ? a_ext : hold_a;
      src_b  = b_vld ? b_ext : hold_b;
      // both directions live and enabled: one reinforced net
      ring   = a_en && b_en && (sel_b == SRC_LIVE) && (sel_a == SRC_LIVE);
      shared = a_vld ? a_ext : (b_vld ? b_ext : hold_a);
      int_b  = (sel_b == SRC_STORED) ? reg_a : (ring ? shared : src_a);
      int_a  = (sel_a == SRC_STORED) ? reg_b : (ring ? shared : src_b);
      a_bus  = a_en ? int_a : src_a;
      b_bus  = b_en ? int_b : src_b;
      a_clash = a_en && a_vld;
      b_clash = b_en && b_vld;
   end
endmodule

// File: rtl/xcvr_half.sv
// One independently controlled slice: two capture registers, keepers, router.
module xcvr_half #(
   parameter int unsigned W       = 8,
   parameter bit          HOLD_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         oe_b,
   input  logic         oe_a_n,
   input  logic         cap_a,
   input  logic         cap_b,
   input  logic         sel_b,
   input  logic         sel_a,
   input  logic [W-1:0] a_ext,
   input  logic         a_vld,
   input  logic [W-1:0] b_ext,
   input  logic         b_vld,
   output logic [W-1:0] a_bus,
   output logic [W-1:0] b_bus,
   output logic         a_en,
   output logic         b_en,
   output logic         a_clash,
   output logic         b_clash
);
   logic [W-1:0] q_a, q_b, hold_a, hold_b;

   xcvr_capture #(.W(W)) u_cap_a (
      .clk(clk), .rst_n(rst_n), .strobe(cap_a), .din(a_bus), .q(q_a));
   xcvr_capture #(.W(W)) u_cap_b (
      .clk(clk), .rst_n(rst_n), .strobe(cap_b), .din(b_bus), .q(q_b));

   generate
      if (HOLD_EN) begin : g_keep
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hold_a <= '0;
               hold_b <= '0;
            end else begin
               hold_a <= a_bus;
               hold_b <= b_bus;
            end
         end
      end else begin : g_nokeep
         assign hold_a = '0;
         assign hold_b = '0;
      end
   endgenerate

   xcvr_route #(.W(W)) u_route (
      .oe_b(oe_b), .oe_a_n(oe_a_n), .sel_b(sel_b), .sel_a(sel_a),
      .a_vld(a_vld), .b_vld(b_vld), .a_ext(a_ext), .b_ext(b_ext),
      .reg_a(q_a), .reg_b(q_b), .hold_a(hold_a), .hold_b(hold_b),
      .a_bus(a_bus), .b_bus(b_bus), .a_en(a_en), .b_en(b_en),
      .a_clash(a_clash), .b_clash(b_clash));
endmodule

// File: rtl/regxcvr_dual.sv
// Multi-slice registered two-way transceiver.
module regxcvr_dual #(
   parameter int unsigned SLICE_W    = 8,
   parameter int unsigned NUM_HALVES = 2,
   parameter bit          HOLD_EN    = 1'b1,
   localparam int unsigned TOT_W     = SLICE_W * NUM_HALVES
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_HALVES-1:0] oe_to_b,
   input  logic [NUM_HALVES-1:0] oe_to_a_n,
   input  logic [NUM_HALVES-1:0] cap_a,
   input  logic [NUM_HALVES-1:0] cap_b,
   input  logic [NUM_HALVES-1:0] sel_to_b,
   input  logic [NUM_HALVES-1:0] sel_to_a,
   input  logic [TOT_W-1:0]      a_in,
   input  logic [NUM_HALVES-1:0] a_in_vld,
   input  logic [TOT_W-1:0]      b_in,
   input  logic [NUM_HALVES-1:0] b_in_vld,
   output logic [TOT_W-1:0]      a_bus,
   output logic [TOT_W-1:0]      b_bus,
   output logic [NUM_HALVES-1:0] a_drive_en,
   output logic [NUM_HALVES-1:0] b_drive_en,
   output logic [NUM_HALVES-1:0] a_clash,
   output logic [NUM_HALVES-1:0] b_clash
);
   generate
      if (SLICE_W < 1) begin : g_bad_width
         $error("regxcvr_dual: SLICE_W must be at least 1");
      end
      if (NUM_HALVES < 1) begin : g_bad_count
         $error("regxcvr_dual: NUM_HALVES must be at least 1");
      end

      for (genvar h = 0; h < NUM_HALVES; h++) begin : g_slice
         xcvr_half #(.W(SLICE_W), .HOLD_EN(HOLD_EN)) u_half (
            .clk     (clk),
            .rst_n   (rst_n),
            .oe_b    (oe_to_b[h]),
            .oe_a_n  (oe_to_a_n[h]),
            .cap_a   (cap_a[h]),
            .cap_b   (cap_b[h]),
            .sel_b   (sel_to_b[h]),
            .sel_a   (sel_to_a[h]),
            .a_ext   (a_in[h*SLICE_W +: SLICE_W]),
            .a_vld   (a_in_vld[h]),
            .b_ext   (b_in[h*SLICE_W +: SLICE_W]),
            .b_vld   (b_in_vld[h]),
            .a_bus   (a_bus[h*SLICE_W +: SLICE_W]),
            .b_bus   (b_bus[h*SLICE_W +: SLICE_W]),
            .a_en    (a_drive_en[h]),
            .b_en    (b_drive_en[h]),
            .a_clash (a_clash[h]),
            .b_clash (b_clash[h]));
      end
   endgenerate
endmodule

// File: rtl/xcvr_half_chk.sv
// Property checker attached to every slice.
module xcvr_half_chk #(
   parameter int unsigned W       = 8,
   parameter bit          HOLD_EN = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         oe_b,
   input logic         oe_a_n,
   input logic         sel_b,
   input logic         sel_a,
   input logic         cap_a,
   input logic         cap_b,
   input logic         a_vld,
   input logic         b_vld,
   input logic [W-1:0] a_ext,
   input logic [W-1:0] b_ext,
   input logic [W-1:0] a_bus,
   input logic [W-1:0] b_bus,
   input logic         a_en,
   input logic         b_en,
   input logic         a_clash,
   input logic         b_clash,
   input logic [W-1:0] q_a,
   input logic [W-1:0] q_b
);
   p_load_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_a) |=> q_a == $past(a_bus));
   p_keep_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_a |=> $stable(q_a));
   p_load_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_b) |=> q_b == $past(b_bus));
   p_keep_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_b |=> $stable(q_b));
   p_stored_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_b && b_en) |-> b_bus == q_a);
   p_stored_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_a && a_en) |-> a_bus == q_b);
   p_isolate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_b && oe_a_n) |-> (!a_en && !b_en));
   p_ext_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (a_vld && !a_en) |-> (a_bus == a_ext && !a_clash));
   p_ext_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (b_vld && !b_en) |-> (b_bus == b_ext && !b_clash));

   generate
      if (HOLD_EN) begin : g_keep_chk
         p_hold_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !a_en && !a_vld) |-> a_bus == $past(a_bus));
         p_hold_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !b_en && !b_vld) |-> b_bus == $past(b_bus));
      end
   endgenerate
endmodule

bind xcvr_half xcvr_half_chk #(.W(W), .HOLD_EN(HOLD_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .oe_b(oe_b), .oe_a_n(oe_a_n),
   .sel_b(sel_b), .sel_a(sel_a), .cap_a(cap_a), .cap_b(cap_b),
   .a_vld(a_vld), .b_vld(b_vld), .a_ext(a_ext), .b_ext(b_ext),
   .a_bus(a_bus), .b_bus(b_bus), .a_en(a_en), .b_en(b_en),
   .a_clash(a_clash), .b_clash(b_clash), .q_a(q_a), .q_b(q_b));

// File: tb/regxcvr_dual_tb_top.sv
module regxcvr_dual_tb_top;
   localparam int SW = 8;
   localparam int NH = 2;
   localparam int TW = SW * NH;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NH-1:0] oe_to_b = '0, oe_to_a_n = '1, cap_a = '0, cap_b = '0;
   logic [NH-1:0] sel_to_b = '0, sel_to_a = '0, a_in_vld = '0, b_in_vld = '0;
   logic [TW-1:0] a_in = '0, b_in = '0;
   logic [TW-1:0] a_bus, b_bus;
   logic [NH-1:0] a_drive_en, b_drive_en, a_clash, b_clash;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   // bench model state
   logic [SW-1:0] m_ra [NH], m_rb [NH], m_ha [NH], m_hb [NH];
   logic          m_ca [NH], m_cb [NH];
   logic [SW-1:0] e_a [NH], e_b [NH];

   always #10 clk = ~clk;

   regxcvr_dual #(.SLICE_W(SW), .NUM_HALVES(NH)) dut_i (
      .clk(clk), .rst_n(rst_n), .oe_to_b(oe_to_b), .oe_to_a_n(oe_to_a_n),
      .cap_a(cap_a), .cap_b(cap_b), .sel_to_b(sel_to_b), .sel_to_a(sel_to_a),
      .a_in(a_in), .a_in_vld(a_in_vld), .b_in(b_in), .b_in_vld(b_in_vld),
      .a_bus(a_bus), .b_bus(b_bus), .a_drive_en(a_drive_en),
      .b_drive_en(b_drive_en), .a_clash(a_clash), .b_clash(b_clash));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // expected bus values from the requirement rules
   task automatic model_eval();
      for (int h = 0; h < NH; h++) begin
         logic [SW-1:0] av, bv, sa, sb, net, ia, ib;
         logic da, db, loopm;
         av = a_in[h*SW +: SW];
         bv = b_in[h*SW +: SW];
         da = !oe_to_a_n[h];
         db = oe_to_b[h];
         sa = a_in_vld[h] ? av : m_ha[h];
         sb = b_in_vld[h] ? bv : m_hb[h];
         loopm = da && db && !sel_to_b[h] && !sel_to_a[h];
         net = a_in_vld[h] ? av : (b_in_vld[h] ? bv : m_ha[h]);
         ib = sel_to_b[h] ? m_ra[h] : (loopm ? net : sa);
         ia = sel_to_a[h] ? m_rb[h] : (loopm ? net : sb);
         e_a[h] = da ? ia : sa;
         e_b[h] = db ? ib : sb;
      end
   endtask

   // inputs were set at a falling edge: compare, then advance one clock
   task automatic cycle(input string tag);
      #1;
      model_eval();
      for (int h = 0; h < NH; h++) begin
         chk({tag, " a_bus"}, 32'(a_bus[h*SW +: SW]), 32'(e_a[h]));
         chk({tag, " b_bus"}, 32'(b_bus[h*SW +: SW]), 32'(e_b[h]));
         chk({tag, " a_drive_en"}, 32'(a_drive_en[h]), 32'(!oe_to_a_n[h]));
         chk({tag, " b_drive_en"}, 32'(b_drive_en[h]), 32'(oe_to_b[h]));
         chk({tag, " a_clash"}, 32'(a_clash[h]), 32'(!oe_to_a_n[h] && a_in_vld[h]));
         chk({tag, " b_clash"}, 32'(b_clash[h]), 32'(oe_to_b[h] && b_in_vld[h]));
      end
      @(posedge clk);
      for (int h = 0; h < NH; h++) begin
         if (cap_a[h] && !m_ca[h]) m_ra[h] = e_a[h];
         if (cap_b[h] && !m_cb[h]) m_rb[h] = e_b[h];
         m_ca[h] = cap_a[h];
         m_cb[h] = cap_b[h];
         m_ha[h] = e_a[h];
         m_hb[h] = e_b[h];
      end
      @(negedge clk);
   endtask

   task automatic set0(input logic ob, oan, sb, sa, ca, cb, av, bv,
                       input logic [7:0] ad, bd);
      oe_to_b[0] = ob; oe_to_a_n[0] = oan; sel_to_b[0] = sb; sel_to_a[0] = sa;
      cap_a[0] = ca; cap_b[0] = cb; a_in_vld[0] = av; b_in_vld[0] = bv;
      a_in[7:0] = ad; b_in[7:0] = bd;
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      for (int h = 0; h < NH; h++) begin
         m_ra[h] = '0; m_rb[h] = '0; m_ha[h] = '0; m_hb[h] = '0;
         m_ca[h] = 1'b0; m_cb[h] = 1'b0;
      end
      a_in = 16'hA5C3; b_in = 16'h3C5A;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      a_in = '0; b_in = '0;
      // R1: keepers at zero, registers at zero (read through stored selects)
      #1;
      chk("R1 a_bus idle", 32'(a_bus), 32'h0);
      chk("R1 b_bus idle", 32'(b_bus), 32'h0);
      oe_to_b = '1; oe_to_a_n = '0; sel_to_b = '1; sel_to_a = '1;
      #1;
      chk("R1 A register via B", 32'(b_bus), 32'h0);
      chk("R1 B register via A", 32'(a_bus), 32'h0);
      cycle("R1");
      oe_to_b = '0; oe_to_a_n = '1; sel_to_b = '0; sel_to_a = '0;

      // R2/R6: capture during isolation, held strobe loads once
      set0(0, 1, 0, 0, 1, 0, 1, 0, 8'h5A, 8'h00);
      cycle("R6 isolated capture");
      set0(0, 1, 0, 0, 1, 0, 1, 0, 8'h33, 8'h00);
      cycle("R2 held strobe");
      set0(1, 1, 1, 0, 0, 0, 0, 0, 8'h00, 8'h00);
      #1 chk("R2 A register kept first value", 32'(b_bus[7:0]), 32'h5A);
      cycle("R2 readback");

      // R3: capture B while A is driven, read via stored A select
      set0(0, 0, 0, 0, 0, 1, 0, 1, 8'h00, 8'hE7);
      cycle("R3 capture B");
      set0(0, 0, 0, 1, 0, 0, 0, 0, 8'h00, 8'h00);
      #1 chk("R3 B register readback", 32'(a_bus[7:0]), 32'hE7);
      cycle("R3 readback");

      // R8: keeper holds after the external driver leaves
      set0(0, 1, 0, 0, 0, 0, 1, 0, 8'h7E, 8'h00);
      cycle("R8 drive");
      set0(0, 1, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00);
      for (int k = 0; k < 3; k++) begin
         #1 chk("R8 A keeper", 32'(a_bus[7:0]), 32'h7E);
         cycle("R8 hold");
      end

      // R10: live select, both strobes together -> both registers get A
      set0(1, 1, 0, 0, 1, 1, 1, 0, 8'hC3, 8'h00);
      cycle("R10 loop-back store");
      set0(1, 0, 1, 1, 0, 0, 0, 0, 8'h00, 8'h00);
      #1;
      chk("R10 A register", 32'(b_bus[7:0]), 32'hC3);
      chk("R10 B register", 32'(a_bus[7:0]), 32'hC3);
      cycle("R10 readback");

      // R11: stored select, both strobes together -> B gets old A register
      set0(1, 1, 1, 0, 1, 1, 1, 0, 8'h96, 8'h00);
      cycle("R11 simultaneous stored");
      set0(1, 0, 1, 1, 0, 0, 0, 0, 8'h00, 8'h00);
      #1;
      chk("R11 A register new", 32'(b_bus[7:0]), 32'h96);
      chk("R11 B register old A", 32'(a_bus[7:0]), 32'hC3);
      cycle("R11 readback");

      // R12: select flips while register equals live value
      set0(1, 1, 0, 0, 0, 0, 1, 0, 8'h96, 8'h00);
      #1 chk("R12 live", 32'(b_bus[7:0]), 32'h96);
      sel_to_b[0] = 1'b1;
      #1 chk("R12 after flip to stored", 32'(b_bus[7:0]), 32'h96);
      sel_to_b[0] = 1'b0;
      #1 chk("R12 after flip to live", 32'(b_bus[7:0]), 32'h96);
      cycle("R12");

      // R9: ring retains its level once external drive goes away
      set0(1, 0, 0, 0, 0, 0, 1, 0, 8'h11, 8'h00);
      #1 chk("R9 ring from A", 32'({a_bus[7:0], b_bus[7:0]}), 32'h1111);
      cycle("R9 set");
      set0(1, 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00);
      for (int k = 0; k < 3; k++) begin
         #1 chk("R9 ring retained", 32'({a_bus[7:0], b_bus[7:0]}), 32'h1111);
         cycle("R9 retain");
      end
      set0(1, 0, 0, 0, 0, 0, 0, 1, 8'h00, 8'h22);
      #1 chk("R9 ring from B", 32'({a_bus[7:0], b_bus[7:0]}), 32'h2222);
      cycle("R9 B source");

      // R4 R5 R7 R13: every control combination per slice, random data/strobes
      for (int rep = 0; rep < 4; rep++) begin
         for (int c = 0; c < 64; c++) begin
            logic [5:0] c0, c1;
            c0 = 6'(c);
            c1 = 6'(c) ^ 6'h2A ^ 6'(rep);
            oe_to_b   = {c1[0], c0[0]};
            oe_to_a_n = {c1[1], c0[1]};
            sel_to_b  = {c1[2], c0[2]};
            sel_to_a  = {c1[3], c0[3]};
            a_in_vld  = {c1[4], c0[4]};
            b_in_vld  = {c1[5], c0[5]};
            a_in  = 16'($urandom);
            b_in  = 16'($urandom);
            cap_a = 2'($urandom);
            cap_b = 2'($urandom);
            cycle("R4 R5 R7 R13 sweep");
         end
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule